// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a scaled-down synchronous static memory whose word is split into byte lanes (two lanes of 9 bits by default, 18 bits in all). Every rising clock edge registers the access: the address, the three chip-select inputs, the write controls and the write data. An access starts when either of two start strobes is low. After that, an advance input steps a 2-bit burst counter over the four words of an aligned group. Read data is flow-through: the word addressed by the state registered at an edge appears on `rd_data` straight after that edge, and no further register sits on the path.

Writes go either to the whole word, through a global write input, or to chosen lanes, through per-lane enables that only act while a lane-write master enable is low. The burst order is linear or interleaved and is chosen per burst. A sleep input stops all accesses. An output enable input gates the read data port without waiting for a clock edge.

Top module: `sbs_sram_top`

## Requirements
- R1: While reset is asserted and after it is released, with no access started, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: An edge with `start_b_n` low, the chip selected and no lane written loads `addr`. The word stored at `addr` is on `rd_data`, with `rd_valid` high, straight after that edge.
- R3: The chip is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 all hold at a start edge. A start with any one of them inactive writes nothing, and `rd_valid` is 0 after that edge.
- R4: `gwr_n`=0 writes every lane of the current word, whatever the values of `lane_en_n` and `lane_wr_n`.
- R5: With `gwr_n`=1, lane i is written only when `lane_en_n`=0 and `lane_wr_n[i]`=0. Lane 0 is `wr_data[8:0]` and lane 1 is `wr_data[17:9]`. With `lane_en_n`=1 nothing is written.
- R6: A start through `start_a_n` is always a read. All write controls are ignored on that edge. When both strobes are low, `start_a_n` wins.
- R7: In linear order (`burst_order`=0 at the start edge), each edge with `adv_n` low and no start adds 1 modulo 4 to the low two address bits and leaves the upper bits unchanged. After four steps the address is back at the start.
- R8: In interleaved order (`burst_order`=1 at the start edge), the low address bits after k advances are the start's low bits XOR (k mod 4).
- R9: An edge with no start and `adv_n` high keeps the current address, so the same word is read again.
- R10: `oe_n`=1 forces `rd_data` to zero and `rd_valid` to 0 at once, with no clock edge needed. `oe_n`=0 restores the output.
- R11: An edge with `sleep`=1 writes nothing and changes no address, and `rd_valid` is 0 after it. The first cycle after sleep ends reads the held address again.
- R12: After an edge that writes any lane, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address loaded by a start |
| start_a_n | input | 1 | Start strobe for read-only accesses, active low |
| start_b_n | input | 1 | Start strobe for general accesses, active low |
| adv_n | input | 1 | Advance the burst counter, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved, taken at the start edge |
| gwr_n | input | 1 | Global write of all lanes, active low |
| lane_en_n | input | 1 | Master enable for lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Standby: blocks every access |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Read data, zero when not driven |
| rd_valid | output | 1 | High when `rd_data` carries a read word |

## Verification
The assertions assume that every control input is known (not X) at each rising edge once reset has been released. They also assume that `oe_n` is the only input that may change between edges with an effect the design has to show at once. The bench changes its inputs only a couple of nanoseconds after an edge and samples after the next edge. It keeps every control driven, and it reads only addresses it has written before, so the uninitialised contents of the array never reach a check. Each burst is started with an explicit order on `burst_order`, so the step assertions always see an order registered at a start.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Burst ordering, captured at the start of each burst.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;

    // Access control state kept in the top level.
    typedef struct packed {
        logic active;   // a selected burst is open
        logic rd;       // the registered cycle was a read
    } sbs_ctl_t;

endpackage

// File: rtl/sbs_burst.sv
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              order,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        burst_ord_e        ord;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic [1:0] off_d, off_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = load_addr;
            st_d.cnt  = 2'd0;
            st_d.ord  = burst_ord_e'(order);
        end else if (step) begin
            st_d.cnt = st_q.cnt + 2'd1;
        end
        off_d = (st_d.ord == ORD_INTERLEAVE) ? (st_d.base[1:0] ^ st_d.cnt)
                                             : (st_d.base[1:0] + st_d.cnt);
        off_q = (st_q.ord == ORD_INTERLEAVE) ? (st_q.base[1:0] ^ st_q.cnt)
                                             : (st_q.base[1:0] + st_q.cnt);
        nxt_addr = {st_d.base[ADDR_W-1:2], off_d};
        cur_addr = {st_q.base[ADDR_W-1:2], off_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: '0, cnt: 2'd0, ord: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    // Upper bits stay fixed while a burst advances.
    p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    // Linear bursts add one to the low bits.
    p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && st_q.ord == ORD_LINEAR)
        |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    // Interleaved bursts: low bits always equal start offset XOR count.
    p_interleave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && st_q.ord == ORD_INTERLEAVE)
        |=> ((cur_addr[1:0] ^ st_q.base[1:0]) == $past(st_q.cnt) + 2'd1));

    // No load, no step: address held.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_addr));

    logic unused_hi;
    assign unused_hi = ^{HI_W{1'b0}};

endmodule

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             gwr_n,
    input  logic             lane_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lanes
);

    always_comb begin
        if (!gwr_n) begin
            lanes = '1;
        end else if (!lane_en_n) begin
            lanes = ~lane_wr_n;
        end else begin
            lanes = '0;
        end
    end

    // Master enable off and no global write: no lane may be selected.
    always_comb begin
        if (gwr_n === 1'b1 && lane_en_n === 1'b1) begin
            a_master_off_r5: assert (lanes == '0);
        end
        if (gwr_n === 1'b0) begin
            a_global_all_r4: assert (&lanes);
        end
    end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/sbs_sram_top.sv
module sbs_sram_top
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    start_a_n,
    input  logic                    start_b_n,
    input  logic                    adv_n,
    input  logic                    burst_order,
    input  logic                    gwr_n,
    input  logic                    lane_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    sleep,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);

    localparam int DATA_W = LANES * LANE_W;

    sbs_ctl_t ctl_d, ctl_q;

    logic              chip_sel;
    logic              start;
    logic              access;
    logic              load;
    logic              step;
    logic [LANES-1:0]  dec_lanes;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] arr_rdata;

    sbs_wr_decode #(.LANES(LANES)) u_dec (
        .gwr_n     (gwr_n),
        .lane_en_n (lane_en_n),
        .lane_wr_n (lane_wr_n),
        .lanes     (dec_lanes)
    );

    sbs_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .order     (burst_order),
        .load_addr (addr),
        .nxt_addr  (nxt_addr),
        .cur_addr  (cur_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (wr_lanes),
        .waddr (nxt_addr),
        .wdata (wr_data),
        .raddr (cur_addr),
        .rdata (arr_rdata)
    );

    // Next-state and access qualification.
    always_comb begin
        chip_sel = !cs0_n && cs1 && !cs2_n;
        start    = !start_a_n || !start_b_n;
        access   = !sleep && (start ? chip_sel : ctl_q.active);
        load     = !sleep && start && chip_sel;
        step     = !sleep && !start && ctl_q.active && !adv_n;
        // A start through strobe A is a read: write controls ignored.
        wr_lanes = (access && start_a_n) ? dec_lanes : '0;

        ctl_d = ctl_q;
        if (sleep) begin
            ctl_d.rd = 1'b0;
        end else if (start) begin
            ctl_d.active = chip_sel;
            ctl_d.rd     = chip_sel && (wr_lanes == '0);
        end else begin
            ctl_d.rd     = ctl_q.active && (wr_lanes == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{active: 1'b0, rd: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Flow-through output with asynchronous enable.
    always_comb begin
        rd_valid = ctl_q.rd && !oe_n;
        rd_data  = rd_valid ? arr_rdata : '0;
    end

    p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && start && !chip_sel) |=> !rd_valid);

    p_strobe_a_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !start_a_n && chip_sel) |=> (rd_valid || oe_n));

    p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rd_valid);

    p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(cur_addr));

    p_write_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lanes != '0) |=> !rd_valid);

    always_comb begin
        if (oe_n === 1'b1) begin
            a_oe_gate_r10: assert (rd_data == '0 && !rd_valid);
        end
    end

endmodule

// File: tb/sbs_sram_top_bench.sv
module sbs_sram_top_bench;

    localparam int ADDR_W = 6;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              start_a_n, start_b_n, adv_n, burst_order;
    logic              gwr_n, lane_en_n;
    logic [LANES-1:0]  lane_wr_n;
    logic              cs0_n, cs1, cs2_n, sleep, oe_n;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    logic [DATA_W-1:0] ref_mem [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sbs_sram_top #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sbs_sram_top (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .start_a_n(start_a_n), .start_b_n(start_b_n), .adv_n(adv_n),
        .burst_order(burst_order), .gwr_n(gwr_n), .lane_en_n(lane_en_n),
        .lane_wr_n(lane_wr_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .sleep(sleep), .oe_n(oe_n), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_idle();
        start_a_n = 1'b1; start_b_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; lane_en_n = 1'b1; lane_wr_n = '1;
        cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        sleep = 1'b0; oe_n = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] pat(int a);
        return DATA_W'(a * 4099 + 18'h0A5C3);
    endfunction

    // Global write of one word, then check output is quiet (R12).
    task automatic write_word(int a, logic [DATA_W-1:0] d);
        set_idle();
        start_b_n = 1'b0; addr = ADDR_W'(a); gwr_n = 1'b0; wr_data = d;
        tick();
        chk("R12 write cycle valid", DATA_W'(rd_valid), '0);
        ref_mem[a] = d;
        set_idle();
    endtask

    task automatic start_read(int a, logic ord);
        set_idle();
        start_b_n = 1'b0; addr = ADDR_W'(a); burst_order = ord;
        tick();
        set_idle();
    endtask

    task automatic t_reset();
        set_idle();
        addr = '0; burst_order = 1'b0; wr_data = '0;
        rst_n = 1'b0;
        tick();
        chk("R1 reset valid", DATA_W'(rd_valid), '0);
        chk("R1 reset data", rd_data, '0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", DATA_W'(rd_valid), '0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 8; a++) write_word(a, pat(a));
        write_word(40, pat(40));
    endtask

    task automatic t_read();
        start_read(5, 1'b0);
        chk("R2 read valid", DATA_W'(rd_valid), 1);
        chk("R2 read data", rd_data, ref_mem[5]);
        start_read(40, 1'b0);
        chk("R2 read data far", rd_data, ref_mem[40]);
    endtask

    task automatic t_linear();
        start_read(6, 1'b0);
        chk("R7 linear start", rd_data, ref_mem[6]);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick();
            chk("R7 linear step", rd_data, ref_mem[4 + ((2 + k) % 4)]);
        end
        set_idle();
    endtask

    task automatic t_interleave();
        start_read(5, 1'b1);
        chk("R8 interleave start", rd_data, ref_mem[5]);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick();
            chk("R8 interleave step", rd_data, ref_mem[4 + (1 ^ (k % 4))]);
        end
        set_idle();
    endtask

    task automatic t_hold();
        start_read(2, 1'b0);
        tick();
        chk("R9 hold data", rd_data, ref_mem[2]);
        tick();
        chk("R9 hold data again", rd_data, ref_mem[2]);
    endtask

    task automatic t_lanes();
        logic [DATA_W-1:0] e;
        // Lane 0 only.
        set_idle();
        start_b_n = 1'b0; addr = 6'd3; lane_en_n = 1'b0; lane_wr_n = 2'b10;
        wr_data = '1;
        tick();
        e = ref_mem[3]; e[8:0] = 9'h1FF; ref_mem[3] = e;
        start_read(3, 1'b0);
        chk("R5 lane0 write", rd_data, ref_mem[3]);
        // Lane 1 only.
        set_idle();
        start_b_n = 1'b0; addr = 6'd4; lane_en_n = 1'b0; lane_wr_n = 2'b01;
        wr_data = '0;
        tick();
        e = ref_mem[4]; e[17:9] = 9'h000; ref_mem[4] = e;
        start_read(4, 1'b0);
        chk("R5 lane1 write", rd_data, ref_mem[4]);
        // Master off: nothing written.
        set_idle();
        start_b_n = 1'b0; addr = 6'd2; lane_en_n = 1'b1; lane_wr_n = 2'b00;
        wr_data = 18'h12345;
        tick();
        start_read(2, 1'b0);
        chk("R5 master off", rd_data, ref_mem[2]);
    endtask

    task automatic t_global();
        set_idle();
        start_b_n = 1'b0; addr = 6'd1; gwr_n = 1'b0; lane_en_n = 1'b1;
        lane_wr_n = 2'b11; wr_data = 18'h2B6D1;
        tick();
        ref_mem[1] = 18'h2B6D1;
        start_read(1, 1'b0);
        chk("R4 global write", rd_data, ref_mem[1]);
    endtask

    task automatic t_strobe_a();
        set_idle();
        start_a_n = 1'b0; start_b_n = 1'b0; addr = 6'd0;
        gwr_n = 1'b0; wr_data = '0;
        tick();
        chk("R6 strobe A valid", DATA_W'(rd_valid), 1);
        chk("R6 strobe A data", rd_data, ref_mem[0]);
        set_idle();
    endtask

    task automatic t_chip_sel();
        for (int i = 0; i < 3; i++) begin
            set_idle();
            if (i == 0) cs0_n = 1'b1;
            if (i == 1) cs1 = 1'b0;
            if (i == 2) cs2_n = 1'b1;
            start_b_n = 1'b0; addr = 6'd0; gwr_n = 1'b0; wr_data = '0;
            tick();
            chk("R3 deselect valid", DATA_W'(rd_valid), '0);
        end
        start_read(0, 1'b0);
        chk("R3 no write when deselected", rd_data, ref_mem[0]);
    endtask

    task automatic t_oe();
        start_read(7, 1'b0);
        oe_n = 1'b1;
        #1;
        chk("R10 oe off data", rd_data, '0);
        chk("R10 oe off valid", DATA_W'(rd_valid), '0);
        oe_n = 1'b0;
        #1;
        chk("R10 oe on data", rd_data, ref_mem[7]);
    endtask

    task automatic t_sleep();
        start_read(5, 1'b0);
        sleep = 1'b1; adv_n = 1'b0; gwr_n = 1'b0; wr_data = '0;
        tick();
        chk("R11 sleep valid", DATA_W'(rd_valid), '0);
        set_idle();
        tick();
        chk("R11 address held", rd_data, ref_mem[5]);
        start_read(6, 1'b0);
        chk("R11 no write in sleep", rd_data, ref_mem[6]);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_read();
        t_linear();
        t_interleave();
        t_hold();
        t_lanes();
        t_global();
        t_strobe_a();
        t_chip_sel();
        t_oe();
        t_sleep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule